// File: doc/BRIEF.md
# Board Connectivity Test Mode Controller

This block adds a board-level connectivity test to a chip whose pins normally do other jobs. A test request pin is looked at once, on the low-to-high transition of an internal reset-release signal. If the request pin is high at that moment, a test-mode flag is set. The flag then stays set until a later reset-release rising edge finds the request pin low.

While the flag is set, two things change. A serial chain of two-input NAND gates, fed by a set of monitored input pins, drives a shared output pin in place of that pin's normal address value. The analog converter that normally drives the request pin has its output enable withdrawn, so external test equipment can own that pin.

To test the board, the equipment drives all monitored pins high. It then pulls them low one at a time and confirms that the shared pin toggles at every step. Outside test mode, the shared pin carries the normal address value and the converter stays enabled.

Top module: `nand_tree_ctl`

## Requirements
- R1: After `rst_n` is released, and before any reset-release rising edge, `test_mode_o` is 0, `shared_pin_o` equals `addr_func_i`, and `dac_en_o` is 1.
- R2: A reset-release rising edge is detected when `rel_i` is high on a `clk` edge after having been low on the previous one. On the clock edge that detects it, the flag loads the value of `test_req_i`, and `test_mode_o` shows that value after this edge.
- R3: Without a detected rising edge, the flag keeps its value. This holds while `test_req_i` changes, while `rel_i` stays high, and when `rel_i` falls.
- R4: A rising edge that samples `test_req_i` low clears a flag that was set.
- R5: While the flag is 1, `shared_pin_o` equals the NAND chain output, and `addr_func_i` has no effect on it.
- R6: While the flag is 1, `dac_en_o` is 0.
- R7: While the flag is 0, `shared_pin_o` equals `addr_func_i`, `dac_en_o` is 1, and `tree_pins_i` has no effect on either output.
- R8: Stage 0 of the chain is the NAND of constant 1 and `tree_pins_i[0]`. Stage k is the NAND of stage k-1 and `tree_pins_i[k]`. The chain output is stage N_PINS-1. With all pins high, the chain output is 1 when N_PINS is even and 0 when N_PINS is odd.
- R9: Let m be the highest index with `tree_pins_i[m]` low. The chain output is 1 when N_PINS-1-m is even and 0 when it is odd. As a result, pulling the pins low one at a time in ascending order toggles the output at every step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rel_i | input | 1 | Reset-release signal; its rising edge samples the request pin |
| test_req_i | input | 1 | Test request pin value |
| tree_pins_i | input | N_PINS | Monitored pins feeding the NAND chain |
| addr_func_i | input | 1 | Normal address value for the shared pin |
| shared_pin_o | output | 1 | Shared address/test output pin |
| dac_en_o | output | 1 | Converter output enable on the request pin |
| test_mode_o | output | 1 | Latched test-mode flag |

## Verification
The assertions check on every cycle that:
- the flag loads the sampled request on a detected rising edge and holds without one;
- test mode withdraws the converter enable and puts the chain output on the shared pin;
- normal mode restores the address value;
- the all-high chain level is correct.

Only the bench's scenarios can show:
- the exact cycle in which a reset-release edge takes effect;
- that a falling edge, or `rel_i` held high, leaves the flag untouched;
- the toggle-per-step walk across the monitored pins;
- the chain level for arbitrary pin patterns, predicted from the highest low pin rather than by rebuilding the chain.

// File: rtl/nt_pkg.sv
package nt_pkg;

  // Two-input NAND used by every chain stage.
  function automatic logic nt_nand2(input logic a, input logic b);
    return ~(a & b);
  endfunction

  // Chain output level expected when every monitored pin is high.
  function automatic logic nt_all_high_level(input int n);
    return ((n % 2) == 0) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/nt_edge_capture.sv
module nt_edge_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_i,
  input  logic req_i,
  output logic mode_o,
  output logic rel_rise_o
);

  logic rel_q;
  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= rel_i;
  end

  assign rel_rise_o = rel_i & ~rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= 1'b0;
    else if (rel_rise_o) mode_q <= req_i;
  end

  assign mode_o = mode_q;

  // R2 / R4: a detected edge loads the sampled request
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_rise_o |=> (mode_o == $past(req_i)));

  // R3: without an edge the flag holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_rise_o |=> $stable(mode_o));

endmodule

// File: rtl/nt_nand_chain.sv
module nt_nand_chain #(
  parameter int N_PINS = 8
) (
  input  logic [N_PINS-1:0] pins_i,
  output logic              tree_o
);
  import nt_pkg::*;

  localparam int LAST = N_PINS - 1;

  for (genvar g = 0; g < N_PINS; g++) begin : g_stage
    logic s;
    if (g == 0) begin : g_first
      assign s = nt_nand2(1'b1, pins_i[0]);
    end else begin : g_next
      assign s = nt_nand2(g_stage[g-1].s, pins_i[g]);
    end
  end

  assign tree_o = g_stage[LAST].s;

endmodule

// File: rtl/nt_pin_mux.sv
module nt_pin_mux (
  input  logic mode_i,
  input  logic tree_i,
  input  logic addr_i,
  output logic pin_o,
  output logic dac_en_o
);

  always_comb begin
    if (mode_i) begin
      pin_o    = tree_i;
      dac_en_o = 1'b0;
    end else begin
      pin_o    = addr_i;
      dac_en_o = 1'b1;
    end
  end

endmodule

// File: rtl/nand_tree_ctl.sv
module nand_tree_ctl #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rel_i,
  input  logic              test_req_i,
  input  logic [N_PINS-1:0] tree_pins_i,
  input  logic              addr_func_i,
  output logic              shared_pin_o,
  output logic              dac_en_o,
  output logic              test_mode_o
);
  import nt_pkg::*;

  logic mode_w;
  logic rel_rise_w;
  logic tree_w;

  nt_edge_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel_i      (rel_i),
    .req_i      (test_req_i),
    .mode_o     (mode_w),
    .rel_rise_o (rel_rise_w)
  );

  nt_nand_chain #(.N_PINS(N_PINS)) u_chain (
    .pins_i (tree_pins_i),
    .tree_o (tree_w)
  );

  nt_pin_mux u_mux (
    .mode_i   (mode_w),
    .tree_i   (tree_w),
    .addr_i   (addr_func_i),
    .pin_o    (shared_pin_o),
    .dac_en_o (dac_en_o)
  );

  assign test_mode_o = mode_w;

  // R5: test mode routes the chain onto the shared pin
  assert_tree_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_o |-> (shared_pin_o == tree_w));

  // R6: test mode withdraws the converter enable
  assert_dac_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_o |-> !dac_en_o);

  // R7: normal mode keeps address function and converter
  assert_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode_o |-> (dac_en_o && shared_pin_o == addr_func_i));

  // R8: all-high level of the chain
  assert_all_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&tree_pins_i) |-> (tree_w == nt_all_high_level(N_PINS)));

endmodule

// File: tb/test_nand_tree_ctl.sv
module test_nand_tree_ctl;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rel = 1'b0;
  logic         req = 1'b0;
  logic [N-1:0] pins = '1;
  logic         addr = 1'b0;
  logic         pin_o;
  logic         dac_en;
  logic         mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nand_tree_ctl #(.N_PINS(N)) i_nand_tree_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rel_i        (rel),
    .test_req_i   (req),
    .tree_pins_i  (pins),
    .addr_func_i  (addr),
    .shared_pin_o (pin_o),
    .dac_en_o     (dac_en),
    .test_mode_o  (mode)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Expected chain level: highest low pin decides, independent of structure.
  function automatic logic model_tree(input logic [N-1:0] p);
    int m = -1;
    for (int i = 0; i < N; i++) if (!p[i]) m = i;
    if (m < 0) return ((N % 2) == 0);
    return (((N - 1 - m) % 2) == 0);
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  // Raise rel with the given request; check mode after the capturing edge.
  task automatic pulse_rel(input logic r);
    @(negedge clk); rel = 1'b0; req = r;
    @(negedge clk); rel = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rel = 1'b0; req = 1'b1; addr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 mode", mode, 1'b0);
    chk("R1 pin", pin_o, 1'b1);
    chk("R1 dac_en", dac_en, 1'b1);
  endtask

  task automatic t_capture();
    pulse_rel(1'b1);
    chk("R2 mode set", mode, 1'b1);
    chk("R6 dac off", dac_en, 1'b0);
  endtask

  task automatic t_hold();
    req = 1'b0; step(); step();
    chk("R3 hold rel high", mode, 1'b1);
    @(negedge clk); rel = 1'b0; step();
    chk("R3 hold rel fall", mode, 1'b1);
    req = 1'b1; step(); req = 1'b0; step();
    chk("R3 hold req toggle", mode, 1'b1);
  endtask

  task automatic t_route();
    pins = '1;
    addr = 1'b0; step();
    chk("R5 all high", pin_o, model_tree(pins));
    chk("R8 all high level", pin_o, 1'b1);
    addr = 1'b1; step();
    chk("R5 addr ignored", pin_o, 1'b1);
    pins = '1; pins[N-1] = 1'b0; addr = 1'b0; step();
    chk("R5 addr ignored low", pin_o, model_tree(pins));
  endtask

  task automatic t_walk();
    logic prev;
    pins = '1; step();
    prev = pin_o;
    for (int j = 0; j < N; j++) begin
      pins[j] = 1'b0; step();
      chk("R9 walk level", pin_o, model_tree(pins));
      chk("R9 walk toggles", pin_o, ~prev);
      prev = pin_o;
    end
  endtask

  task automatic t_patterns();
    logic [N-1:0] lf = 8'hA5;
    for (int k = 0; k < 20; k++) begin
      lf = {lf[N-2:0], lf[N-1] ^ lf[5] ^ lf[4] ^ lf[3]};
      pins = lf; step();
      chk("R9 pattern", pin_o, model_tree(pins));
    end
  endtask

  task automatic t_clear();
    pulse_rel(1'b0);
    chk("R4 mode cleared", mode, 1'b0);
    chk("R7 dac on", dac_en, 1'b1);
    for (int k = 0; k < 4; k++) begin
      addr = k[0]; pins = k[1] ? '0 : '1; step();
      chk("R7 pin addr", pin_o, k[0]);
    end
    pins = '1; pulse_rel(1'b1);
    chk("R2 re-enter", mode, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_capture();
        t_hold();
        t_route();
        t_walk();
        t_patterns();
        t_clear();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule